// File: doc/BRIEF.md
# Cross-Cluster Forward Request Selector

This block belongs to the second issue-select stage of a clustered execution core. Each cycle it sees up to six candidate instructions. Each candidate has a destination register index, two source register indices and a ready flag per source from the scoreboard. A source register that sits in another cluster's register file has to be pushed to the consuming cluster by the unit that owns it. This block decides which of those pushes are requested in the coming cycle. It does not wait for a pending bit to be set, so a forward can leave in the same cycle as the instruction it feeds.

Every owning unit has its own forward ports: one port each for the A, C and L units, and two each for the B and S units. Candidates compete for these ports, and there is also a global cap on forwards per cycle. For every port the block drives a valid flag and the address to forward. For every candidate operand it drives a grant flag, which the scoreboard uses to clear that register's pending bit. All outputs are registered and appear one clock after the inputs that produced them.

Top module: `fwd_select`

## Requirements
- R1: While `rst_n` is low, and on the first output cycle after reset, every port valid and every grant output is 0.
- R2: A source operand requests a forward only when its slot is valid, its ready flag is 1, its cluster field (address bits [9:7]: A=0, B=1, C=2, L=3, S=4) differs from the destination's cluster field, and the field is one of those five codes. Codes 5 to 7 never request.
- R3: Port index maps to owning unit as 0=A, 1 and 2=B, 3=C, 4=L, 5 and 6=S. A valid port carries the full 10-bit address of the forwarded register.
- R4: Requests are served in order of slot 0 to 5, with src1 before src2 inside a slot. Inside one unit, the lower port index is filled first. A request that finds no free port of its unit is not granted.
- R5: At most MAX_FWD (default 4) ports are valid in any cycle. A new address that arrives after the cap is reached is not granted.
- R6: A request for an address that already holds a port in the same cycle is granted without using another port, even when the cap has been reached.
- R7: `grant_src1_o[i]` and `grant_src2_o[i]` are 1 exactly when that operand of slot i is served by a port, either newly or merged.
- R8: Outputs change only at a clock edge and reflect the inputs present at the previous edge.
- R9: An invalid slot produces neither port use nor a grant, whatever its sources and ready flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid_i | input | 6 | Candidate slot valid |
| cand_src1_i | input | 60 | Source 1 address per slot, slot i at bits [10i+9:10i] |
| cand_src2_i | input | 60 | Source 2 address per slot |
| cand_dst_i | input | 60 | Destination address per slot |
| src1_rdy_i | input | 6 | Scoreboard ready flag of source 1 per slot |
| src2_rdy_i | input | 6 | Scoreboard ready flag of source 2 per slot |
| fwd_valid_o | output | 7 | Forward port valid, one per port |
| fwd_addr_o | output | 70 | Forward address per port, port p at bits [10p+9:10p] |
| grant_src1_o | output | 6 | Source 1 of slot i was forwarded |
| grant_src2_o | output | 6 | Source 2 of slot i was forwarded |

## Verification
The hardest case to reach is a duplicate address that appears after the per-cycle cap is already used up. It only arises when four different units are already served by earlier slots and a later slot names the same register as an earlier grant. A dedicated task builds this case. Slots 0 and 1 share one B register. Slots 2 to 4 fill the A, C and L ports to reach the cap. Slot 5 then names the shared B register again. The expected result is that all six operands are granted while only four ports are valid. Separate tasks press on a single unit's port limit and on the src1-over-src2 order inside one slot.

// File: rtl/fwdsel_pkg.sv
package fwdsel_pkg;
    localparam int NUM_UNITS = 5;
    localparam int UNIT_W    = 3;
    localparam int UNIT_PORTS [NUM_UNITS] = '{1, 2, 1, 1, 2};

    function automatic int sum_ports();
        int s;
        s = 0;
        for (int u = 0; u < NUM_UNITS; u++) s += UNIT_PORTS[u];
        return s;
    endfunction

    localparam int NUM_PORTS = sum_ports();

    // owning unit of a port index; ports are grouped by unit in ascending order
    function automatic int port_unit(int p);
        int base;
        int res;
        base = 0;
        res  = 0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (p >= base && p < base + UNIT_PORTS[u]) res = u;
            base += UNIT_PORTS[u];
        end
        return res;
    endfunction
endpackage

// File: rtl/fwdsel_qualify.sv
module fwdsel_qualify
    import fwdsel_pkg::*;
#(
    parameter int REG_W = 10
) (
    input  logic             slot_valid,
    input  logic             src_rdy,
    input  logic [REG_W-1:0] src_addr,
    input  logic [REG_W-1:0] dst_addr,
    output logic             req
);
    logic [UNIT_W-1:0] src_unit;
    logic [UNIT_W-1:0] dst_unit;

    assign src_unit = src_addr[REG_W-1 -: UNIT_W];
    assign dst_unit = dst_addr[REG_W-1 -: UNIT_W];

    always_comb begin
        req = slot_valid && src_rdy && (src_unit != dst_unit)
              && (int'(src_unit) < NUM_UNITS);
    end
endmodule

// File: rtl/fwdsel_alloc.sv
module fwdsel_alloc
    import fwdsel_pkg::*;
#(
    parameter int NREQ    = 12,
    parameter int REG_W   = 10,
    parameter int MAX_FWD = 4
) (
    input  logic [NREQ-1:0]            req_v,
    input  logic [NREQ*REG_W-1:0]      req_addr,
    output logic [NUM_PORTS-1:0]       port_v,
    output logic [NUM_PORTS*REG_W-1:0] port_addr,
    output logic [NREQ-1:0]            grant
);
    always_comb begin
        int   used;
        logic hit;
        logic placed;
        logic [REG_W-1:0] a;
        port_v    = '0;
        port_addr = '0;
        grant     = '0;
        used      = 0;
        for (int k = 0; k < NREQ; k++) begin
            a      = req_addr[k*REG_W +: REG_W];
            hit    = 1'b0;
            placed = 1'b0;
            if (req_v[k]) begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (port_v[p] && port_addr[p*REG_W +: REG_W] == a) hit = 1'b1;
                end
                if (hit) begin
                    grant[k] = 1'b1;
                end else if (used < MAX_FWD) begin
                    for (int p = 0; p < NUM_PORTS; p++) begin
                        if (!placed && !port_v[p] &&
                            a[REG_W-1 -: UNIT_W] == UNIT_W'(port_unit(p))) begin
                            port_v[p]                  = 1'b1;
                            port_addr[p*REG_W +: REG_W] = a;
                            placed                     = 1'b1;
                        end
                    end
                    if (placed) begin
                        grant[k] = 1'b1;
                        used     = used + 1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwdsel_pkg::*;
#(
    parameter int SLOTS   = 6,
    parameter int REG_W   = 10,
    parameter int MAX_FWD = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           cand_valid_i,
    input  logic [SLOTS*REG_W-1:0]     cand_src1_i,
    input  logic [SLOTS*REG_W-1:0]     cand_src2_i,
    input  logic [SLOTS*REG_W-1:0]     cand_dst_i,
    input  logic [SLOTS-1:0]           src1_rdy_i,
    input  logic [SLOTS-1:0]           src2_rdy_i,
    output logic [NUM_PORTS-1:0]       fwd_valid_o,
    output logic [NUM_PORTS*REG_W-1:0] fwd_addr_o,
    output logic [SLOTS-1:0]           grant_src1_o,
    output logic [SLOTS-1:0]           grant_src2_o
);
    localparam int NREQ = 2 * SLOTS;

    typedef struct packed {
        logic [NUM_PORTS-1:0]       fwd_v;
        logic [NUM_PORTS*REG_W-1:0] fwd_a;
        logic [SLOTS-1:0]           g1;
        logic [SLOTS-1:0]           g2;
    } state_t;

    state_t st_d, st_q;

    logic [NREQ-1:0]            req_v;
    logic [NREQ*REG_W-1:0]      req_addr;
    logic [NUM_PORTS-1:0]       port_v;
    logic [NUM_PORTS*REG_W-1:0] port_addr;
    logic [NREQ-1:0]            grant;

    // request k = 2*slot + operand (operand 0 = src1), giving slot-then-src1 order
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        fwdsel_qualify #(.REG_W(REG_W)) u_q1 (
            .slot_valid (cand_valid_i[i]),
            .src_rdy    (src1_rdy_i[i]),
            .src_addr   (cand_src1_i[i*REG_W +: REG_W]),
            .dst_addr   (cand_dst_i[i*REG_W +: REG_W]),
            .req        (req_v[2*i])
        );
        fwdsel_qualify #(.REG_W(REG_W)) u_q2 (
            .slot_valid (cand_valid_i[i]),
            .src_rdy    (src2_rdy_i[i]),
            .src_addr   (cand_src2_i[i*REG_W +: REG_W]),
            .dst_addr   (cand_dst_i[i*REG_W +: REG_W]),
            .req        (req_v[2*i+1])
        );
        assign req_addr[(2*i)*REG_W +: REG_W]   = cand_src1_i[i*REG_W +: REG_W];
        assign req_addr[(2*i+1)*REG_W +: REG_W] = cand_src2_i[i*REG_W +: REG_W];
    end

    fwdsel_alloc #(.NREQ(NREQ), .REG_W(REG_W), .MAX_FWD(MAX_FWD)) u_alloc (
        .req_v     (req_v),
        .req_addr  (req_addr),
        .port_v    (port_v),
        .port_addr (port_addr),
        .grant     (grant)
    );

    always_comb begin
        st_d = '0;
        if (rst_n) begin
            st_d.fwd_v = port_v;
            st_d.fwd_a = port_addr;
            for (int i = 0; i < SLOTS; i++) begin
                st_d.g1[i] = grant[2*i];
                st_d.g2[i] = grant[2*i+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fwd_valid_o  = st_q.fwd_v;
    assign fwd_addr_o   = st_q.fwd_a;
    assign grant_src1_o = st_q.g1;
    assign grant_src2_o = st_q.g2;

    // ---------------- assertions ----------------
    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fwd_valid_o) <= MAX_FWD);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (fwd_valid_o == '0 && grant_src1_o == '0 && grant_src2_o == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        p_port_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_valid_o[p] |->
                fwd_addr_o[p*REG_W + REG_W-1 -: UNIT_W] == UNIT_W'(port_unit(p)));
        for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
            p_no_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(fwd_valid_o[p] && fwd_valid_o[q] &&
                  fwd_addr_o[p*REG_W +: REG_W] == fwd_addr_o[q*REG_W +: REG_W]));
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot_chk
        p_invalid_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cand_valid_i[i] |=> (!grant_src1_o[i] && !grant_src2_o[i]));
        p_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !src1_rdy_i[i] |=> !grant_src1_o[i]);
        p_same_cluster_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_src2_i[i*REG_W + REG_W-1 -: UNIT_W] ==
             cand_dst_i[i*REG_W + REG_W-1 -: UNIT_W]) |=> !grant_src2_o[i]);
    end
endmodule

// File: tb/fwd_select_bench.sv
module fwd_select_bench;
    localparam int S = 6;
    localparam int W = 10;
    localparam int P = 7;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [S-1:0]   cv, r1, r2;
    logic [S*W-1:0] s1, s2, dd;
    logic [P-1:0]   fv;
    logic [P*W-1:0] fa;
    logic [S-1:0]   g1, g2;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fwd_select u_fwd_select (
        .clk(clk), .rst_n(rst_n),
        .cand_valid_i(cv), .cand_src1_i(s1), .cand_src2_i(s2), .cand_dst_i(dd),
        .src1_rdy_i(r1), .src2_rdy_i(r2),
        .fwd_valid_o(fv), .fwd_addr_o(fa),
        .grant_src1_o(g1), .grant_src2_o(g2)
    );

    function automatic logic [W-1:0] ra(int unit, int idx);
        return {3'(unit), 7'(idx)};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        cv = '0; r1 = '0; r2 = '0; s1 = '0; s2 = '0; dd = '0;
    endtask

    task automatic slot(int i, logic [W-1:0] a1, logic rd1, logic [W-1:0] a2,
                        logic rd2, logic [W-1:0] d);
        cv[i] = 1'b1;
        s1[i*W +: W] = a1; r1[i] = rd1;
        s2[i*W +: W] = a2; r2[i] = rd2;
        dd[i*W +: W] = d;
    endtask

    function automatic logic [63:0] port(int p);
        return 64'(fa[p*W +: W]);
    endfunction

    // inputs driven at negedge; one rising edge later the next negedge sees results
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        clr();
        slot(0, ra(1, 3), 1, ra(2, 4), 1, ra(0, 0));
        step(); step();
        chk("R1 valid in reset", 64'(fv), 0);
        chk("R1 grants in reset", 64'({g1, g2}), 0);
        rst_n = 1'b1;
        clr();
        step();
        chk("R1 valid after reset", 64'(fv), 0);
    endtask

    task automatic t_basic();
        clr();
        slot(0, ra(1, 3), 1, ra(0, 7), 1, ra(0, 5));
        step();
        chk("R3 B uses port1", 64'(fv), 64'b0000010);
        chk("R3 addr on port1", port(1), 64'(ra(1, 3)));
        chk("R7 grant src1", 64'(g1), 64'b000001);
        chk("R2 same cluster no grant", 64'(g2), 0);
    endtask

    task automatic t_reject();
        clr();
        slot(0, ra(2, 1), 0, ra(5, 2), 1, ra(0, 0));
        slot(1, ra(1, 9), 1, ra(3, 9), 1, ra(0, 0));
        cv[1] = 1'b0;
        step();
        chk("R2 not ready / bad unit", 64'(fv), 0);
        chk("R9 invalid slot no grant", 64'({g1, g2}), 0);
    endtask

    task automatic t_unit_limit();
        clr();
        slot(0, ra(1, 10), 1, ra(0, 1), 0, ra(0, 0));
        slot(1, ra(1, 11), 1, ra(0, 1), 0, ra(0, 0));
        slot(2, ra(1, 12), 1, ra(0, 1), 0, ra(0, 0));
        step();
        chk("R4 B ports used", 64'(fv), 64'b0000110);
        chk("R4 port1 slot0", port(1), 64'(ra(1, 10)));
        chk("R4 port2 slot1", port(2), 64'(ra(1, 11)));
        chk("R4 slot2 loses", 64'(g1), 64'b000011);
    endtask

    task automatic t_src_order();
        clr();
        slot(0, ra(3, 2), 1, ra(3, 3), 1, ra(0, 0));
        step();
        chk("R4 src1 wins L port", port(4), 64'(ra(3, 2)));
        chk("R4 src2 not granted", 64'({g1, g2}), 64'({6'b000001, 6'b000000}));
    endtask

    task automatic t_cap();
        clr();
        slot(0, ra(0, 1), 1, ra(1, 1), 1, ra(2, 0));
        slot(1, ra(2, 1), 1, ra(3, 1), 1, ra(0, 0));
        slot(2, ra(4, 1), 1, ra(0, 1), 0, ra(0, 0));
        step();
        chk("R5 four ports A B C L", 64'(fv), 64'b0011011);
        chk("R3 S port addr zero", port(5), 0);
        chk("R5 S over cap not granted", 64'(g1), 64'b000011);
        chk("R5 grants src2", 64'(g2), 64'b000011);
    endtask

    task automatic t_merge();
        clr();
        slot(0, ra(1, 9), 1, ra(0, 0), 0, ra(0, 0));
        slot(1, ra(0, 0), 0, ra(1, 9), 1, ra(2, 0));
        slot(2, ra(0, 1), 1, ra(0, 0), 0, ra(1, 0));
        slot(3, ra(2, 1), 1, ra(0, 0), 0, ra(0, 0));
        slot(4, ra(3, 1), 1, ra(0, 0), 0, ra(0, 0));
        slot(5, ra(1, 9), 1, ra(0, 0), 0, ra(4, 0));
        step();
        chk("R6 one port for shared reg", 64'(fv), 64'b0011011);
        chk("R6 shared addr port1", port(1), 64'(ra(1, 9)));
        chk("R6 merged src1 grants", 64'(g1), 64'b111101);
        chk("R6 merged src2 grant", 64'(g2), 64'b000010);
    endtask

    task automatic t_latency();
        clr();
        slot(0, ra(4, 6), 1, ra(0, 0), 0, ra(0, 0));
        step();
        clr();
        #2;
        chk("R8 holds until edge", 64'(fv), 64'b0100000);
        chk("R8 S addr", port(5), 64'(ra(4, 6)));
        step();
        chk("R8 cleared after edge", 64'(fv), 0);
    endtask

    initial begin
        fork
            begin
                clr();
                rst_n = 1'b0;
                @(negedge clk);
                t_reset();
                t_basic();
                t_reject();
                t_unit_limit();
                t_src_order();
                t_cap();
                t_merge();
                t_latency();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule